// File: doc/BRIEF.md
# NOR Flash Buffered-Program Sequencer

This block turns one buffered-program request into the exact series of write cycles a parallel NOR flash expects. A request is a start address, a word count and a start pulse. The data words then arrive on a valid/ready stream. The sequencer issues two unlock writes and a buffer-load command. It then writes the count word and each data word at successive half-word addresses. It closes with a confirm command, which goes to the address of the last data word. A one-cycle `done` pulse marks the cycle in which the confirm write is on the bus.

The bus side is a registered write port: one strobe, one address and one data word per cycle. An external bus controller turns it into chip-select and write-enable timing. The data stream can stall the sequencer at any time. No bus cycle is issued in the data phase unless a word is present. A request whose count is zero or larger than the buffer capacity is refused. It gets a one-cycle `error` pulse and no bus traffic. Polling for the end of programming and checks on buffer-boundary alignment are left to the surrounding logic.

Top module: `nor_wbp`

## Requirements
- R1: The first two bus writes of an accepted request are data 0xAA at address 0x555 and then data 0x55 at address 0x2AA. They fall on consecutive cycles, and the first is visible in the cycle after the start pulse.
- R2: The third write carries data 0x25 to the start address, in the cycle right after the second unlock write.
- R3: The fourth write goes to the start address and carries the word count minus one, in the cycle right after the buffer-load command.
- R4: Data word i (counting from 0) is written to start address + i, modulo 2^AW, in the order received. Each word is written in the cycle after its valid/ready handshake.
- R5: `din_ready` is high only while data words are still owed. In the data phase a bus write happens only for a handshake, so a stalled stream produces no bus cycles.
- R6: After the last data word, data 0x29 is written to the address of that last word. `done` is high for exactly that one cycle, `busy` is low in that cycle, and the block then accepts a new start.
- R7: A start with count 0 or count greater than MAX_WORDS gives a one-cycle `error` pulse in the next cycle. It produces no bus write, and `busy` stays low.
- R8: A start pulse while `busy` is high is ignored. The running sequence continues unchanged.
- R9: After reset `bus_we`, `done`, `error`, `busy` and `din_ready` are all low.
- R10: A count of exactly MAX_WORDS is accepted and programmed in full. A count of 1 gives a count word of 0 and a confirm write at the start address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request pulse; sampled only when idle |
| start_addr | input | AW | First half-word address of the buffer |
| word_count | input | CNT_W | Number of data words in the request |
| din_valid | input | 1 | Data word present |
| din_data | input | DW | Data word |
| din_ready | output | 1 | Sequencer will take a word at this edge |
| bus_we | output | 1 | One flash write cycle this clock |
| bus_addr | output | AW | Half-word address of the write |
| bus_data | output | DW | Data of the write |
| done | output | 1 | Confirm write on the bus this cycle |
| error | output | 1 | Request refused for a bad count |
| busy | output | 1 | A sequence is in progress |

## Verification
The bound checker looks at every cycle. It checks that a rising `busy` comes with the first unlock write and is followed by the second one. It checks that `din_ready` is never high when the block is idle. It checks that `done` always carries the confirm command with `busy` low, that `error` never coincides with bus traffic, and that `done` and `error` are never high together. The data addresses and values, the wrap of the address, the count word, the confirm address, and whether a start pulse in mid-sequence is ignored all depend on the request. Only the bench can show these. It compares every bus write against a queue it builds from the request, under random stalls of the stream.

// File: rtl/nor_wbp_pkg.sv
package nor_wbp_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_UNLOCK2,
      ST_LOAD,
      ST_COUNT,
      ST_DATA,
      ST_CONFIRM
   } wbp_state_e;

   // command values and unlock offsets; the flash decodes them literally
   localparam logic [7:0]  CMD_UNLOCK_A = 8'hAA;
   localparam logic [7:0]  CMD_UNLOCK_B = 8'h55;
   localparam logic [7:0]  CMD_BUF_LOAD = 8'h25;
   localparam logic [7:0]  CMD_CONFIRM  = 8'h29;
   localparam logic [10:0] OFS_UNLOCK_A = 11'h555;
   localparam logic [10:0] OFS_UNLOCK_B = 11'h2AA;

endpackage

// File: rtl/nor_wbp_count_chk.sv
module nor_wbp_count_chk #(
   parameter int CNT_W     = 8,
   parameter int MAX_WORDS = 32
) (
   input  logic [CNT_W-1:0] count,
   output logic             count_ok
);
   localparam longint CNT_MAX = (64'd1 << CNT_W) - 1;

   generate
      if (CNT_MAX <= MAX_WORDS) begin : g_no_upper
         // every non-zero count fits the buffer
         assign count_ok = (count != '0);
      end else begin : g_upper
         localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_WORDS);
         assign count_ok = (count != '0) && (count <= LIMIT);
      end
   endgenerate
endmodule

// File: rtl/nor_wbp_addr_gen.sv
module nor_wbp_addr_gen #(
   parameter int AW = 24
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] base,
   input  logic          step,
   output logic [AW-1:0] cur_addr,
   output logic [AW-1:0] last_addr
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_addr  <= '0;
         last_addr <= '0;
      end else if (load) begin
         cur_addr  <= base;
         last_addr <= base;
      end else if (step) begin
         last_addr <= cur_addr;
         cur_addr  <= cur_addr + AW'(1);
      end
   end
endmodule

// File: rtl/nor_wbp_seq.sv
module nor_wbp_seq
   import nor_wbp_pkg::*;
#(
   parameter int AW    = 24,
   parameter int DW    = 16,
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CNT_W-1:0] count,
   input  logic             count_ok,
   input  logic [AW-1:0]    cur_addr,
   input  logic [AW-1:0]    last_addr,
   input  logic             din_valid,
   input  logic [DW-1:0]    din_data,
   output logic             din_ready,
   output logic             addr_load,
   output logic             addr_step,
   output logic             bus_we,
   output logic [AW-1:0]    bus_addr,
   output logic [DW-1:0]    bus_data,
   output logic             done,
   output logic             error,
   output logic             busy
);
   wbp_state_e       state;
   logic [CNT_W-1:0] remain;
   logic [CNT_W-1:0] count_m1;

   assign din_ready = (state == ST_DATA);
   assign busy      = (state != ST_IDLE);
   assign addr_load = (state == ST_IDLE) && start && count_ok;
   assign addr_step = (state == ST_DATA) && din_valid;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         remain   <= '0;
         count_m1 <= '0;
         bus_we   <= 1'b0;
         bus_addr <= '0;
         bus_data <= '0;
         done     <= 1'b0;
         error    <= 1'b0;
      end else begin
         bus_we <= 1'b0;
         done   <= 1'b0;
         error  <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (start) begin
                  if (count_ok) begin
                     bus_we   <= 1'b1;
                     bus_addr <= AW'(OFS_UNLOCK_A);
                     bus_data <= DW'(CMD_UNLOCK_A);
                     remain   <= count;
                     count_m1 <= count - CNT_W'(1);
                     state    <= ST_UNLOCK2;
                  end else begin
                     error <= 1'b1;
                  end
               end
            end
            ST_UNLOCK2: begin
               bus_we   <= 1'b1;
               bus_addr <= AW'(OFS_UNLOCK_B);
               bus_data <= DW'(CMD_UNLOCK_B);
               state    <= ST_LOAD;
            end
            ST_LOAD: begin
               bus_we   <= 1'b1;
               bus_addr <= cur_addr;
               bus_data <= DW'(CMD_BUF_LOAD);
               state    <= ST_COUNT;
            end
            ST_COUNT: begin
               bus_we   <= 1'b1;
               bus_addr <= cur_addr;
               bus_data <= DW'(count_m1);
               state    <= ST_DATA;
            end
            ST_DATA: begin
               if (din_valid) begin
                  bus_we   <= 1'b1;
                  bus_addr <= cur_addr;
                  bus_data <= din_data;
                  remain   <= remain - CNT_W'(1);
                  if (remain == CNT_W'(1)) state <= ST_CONFIRM;
               end
            end
            ST_CONFIRM: begin
               bus_we   <= 1'b1;
               bus_addr <= last_addr;
               bus_data <= DW'(CMD_CONFIRM);
               done     <= 1'b1;
               state    <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/nor_wbp.sv
module nor_wbp #(
   parameter int AW        = 24,
   parameter int DW        = 16,
   parameter int MAX_WORDS = 32,
   parameter int CNT_W     = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [AW-1:0]    start_addr,
   input  logic [CNT_W-1:0] word_count,
   input  logic             din_valid,
   input  logic [DW-1:0]    din_data,
   output logic             din_ready,
   output logic             bus_we,
   output logic [AW-1:0]    bus_addr,
   output logic [DW-1:0]    bus_data,
   output logic             done,
   output logic             error,
   output logic             busy
);
   generate
      if (AW < 11) begin : g_bad_aw
         $error("nor_wbp: AW must hold the unlock offsets");
      end
      if (DW < 8) begin : g_bad_dw
         $error("nor_wbp: DW must carry 8-bit commands");
      end
      if (CNT_W > DW) begin : g_bad_cw
         $error("nor_wbp: count word must fit the data bus");
      end
      if (MAX_WORDS < 1) begin : g_bad_max
         $error("nor_wbp: MAX_WORDS must be at least 1");
      end
   endgenerate

   logic          count_ok;
   logic          addr_load;
   logic          addr_step;
   logic [AW-1:0] cur_addr;
   logic [AW-1:0] last_addr;

   nor_wbp_count_chk #(.CNT_W(CNT_W), .MAX_WORDS(MAX_WORDS)) u_cnt (
      .count    (word_count),
      .count_ok (count_ok)
   );

   nor_wbp_addr_gen #(.AW(AW)) u_addr (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (addr_load),
      .base      (start_addr),
      .step      (addr_step),
      .cur_addr  (cur_addr),
      .last_addr (last_addr)
   );

   nor_wbp_seq #(.AW(AW), .DW(DW), .CNT_W(CNT_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .count     (word_count),
      .count_ok  (count_ok),
      .cur_addr  (cur_addr),
      .last_addr (last_addr),
      .din_valid (din_valid),
      .din_data  (din_data),
      .din_ready (din_ready),
      .addr_load (addr_load),
      .addr_step (addr_step),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .bus_data  (bus_data),
      .done      (done),
      .error     (error),
      .busy      (busy)
   );
endmodule

// File: rtl/nor_wbp_chk.sv
module nor_wbp_chk #(
   parameter int AW = 24,
   parameter int DW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          din_ready,
   input logic          bus_we,
   input logic [AW-1:0] bus_addr,
   input logic [DW-1:0] bus_data,
   input logic          done,
   input logic          error,
   input logic          busy
);
   // R1
   unlock_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> bus_we && bus_addr == AW'(11'h555) && bus_data == DW'(8'hAA));

   // R1
   unlock_second_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |=> bus_we && bus_addr == AW'(11'h2AA) && bus_data == DW'(8'h55));

   // R5
   ready_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      din_ready |-> busy);

   // R6
   done_confirm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> bus_we && bus_data == DW'(8'h29) && !busy);

   // R7
   error_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      error |-> !bus_we && !busy);

   // R6
   done_error_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({done, error}));
endmodule

bind nor_wbp nor_wbp_chk #(.AW(AW), .DW(DW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .din_ready (din_ready),
   .bus_we    (bus_we),
   .bus_addr  (bus_addr),
   .bus_data  (bus_data),
   .done      (done),
   .error     (error),
   .busy      (busy)
);

// File: tb/nor_wbp_bench.sv
module nor_wbp_bench;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 24;
   localparam int DW = 16;
   localparam int MAX_WORDS = 32;
   localparam int CNT_W = 8;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start = 1'b0;
   logic [AW-1:0]    start_addr = '0;
   logic [CNT_W-1:0] word_count = '0;
   logic             din_valid = 1'b0;
   logic [DW-1:0]    din_data = '0;
   logic             din_ready;
   logic             bus_we;
   logic [AW-1:0]    bus_addr;
   logic [DW-1:0]    bus_data;
   logic             done;
   logic             error;
   logic             busy;

   int checks = 0;
   int errors = 0;

   logic [AW-1:0] exp_a[$];
   logic [DW-1:0] exp_d[$];
   logic [DW-1:0] words[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   nor_wbp #(.AW(AW), .DW(DW), .MAX_WORDS(MAX_WORDS), .CNT_W(CNT_W)) u_nor_wbp (
      .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
      .word_count(word_count), .din_valid(din_valid), .din_data(din_data),
      .din_ready(din_ready), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_data(bus_data), .done(done), .error(error), .busy(busy)
   );

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic string req_of(input int pos, input int n);
      if (pos < 2) return "R1";
      if (pos == 2) return "R2";
      if (pos == 3) return "R3";
      if (pos < 4 + n) return "R4";
      return "R6";
   endfunction

   // expected write list built from the request alone
   task automatic build_expect(input logic [AW-1:0] a, input int n);
      exp_a.delete(); exp_d.delete(); words.delete();
      exp_a.push_back(AW'(11'h555)); exp_d.push_back(16'h00AA);
      exp_a.push_back(AW'(11'h2AA)); exp_d.push_back(16'h0055);
      exp_a.push_back(a);            exp_d.push_back(16'h0025);
      exp_a.push_back(a);            exp_d.push_back(DW'(n - 1));
      for (int i = 0; i < n; i++) begin
         logic [DW-1:0] w;
         w = DW'($urandom);
         words.push_back(w);
         exp_a.push_back(a + AW'(i));
         exp_d.push_back(w);
      end
      exp_a.push_back(a + AW'(n - 1)); exp_d.push_back(16'h0029);
   endtask

   task automatic run_xfer(input logic [AW-1:0] a, input int n, input bit poke);
      int pos = 0;
      int idx = 0;
      int cyc = 0;
      bit seen_done = 0;
      build_expect(a, n);
      @(negedge clk);
      start = 1'b1; start_addr = a; word_count = CNT_W'(n); din_valid = 1'b0;
      @(negedge clk);
      start = 1'b0;
      while (!seen_done && cyc < 2000) begin
         // observe outputs of the last edge
         if (bus_we) begin
            if (pos < exp_a.size()) begin
               check(bus_addr == exp_a[pos], req_of(pos, n), bus_addr, exp_a[pos]);
               check(bus_data == exp_d[pos], req_of(pos, n), bus_data, exp_d[pos]);
            end else begin
               check(1'b0, "R5 extra write", bus_addr, 0);
            end
            pos++;
         end
         if (din_ready && !busy) check(1'b0, "R5 ready while idle", din_ready, 0);
         if (done) begin
            seen_done = 1;
            check(pos == exp_a.size(), "R6 write count at done", pos, exp_a.size());
            check(bus_we && !busy, "R6 done with confirm, busy low", {bus_we, busy}, 2'b10);
         end
         // drive inputs for the next edge
         if (poke && cyc == 4) begin
            start = 1'b1; start_addr = '0; word_count = CNT_W'(5); // R8
         end else begin
            start = 1'b0;
         end
         din_valid = ($urandom % 4) != 0;
         din_data  = (idx < n) ? words[idx] : DW'($urandom);
         if (din_ready && din_valid) idx++;
         cyc++;
         @(negedge clk);
      end
      din_valid = 1'b0;
      if (!seen_done) check(1'b0, "R6 done never seen", 0, 1);
      check(!bus_we && !busy, "R6 quiet after done", {bus_we, busy}, 0);
   endtask

   task automatic run_bad(input int n);
      @(negedge clk);
      start = 1'b1; start_addr = AW'(24'h4000); word_count = CNT_W'(n);
      @(negedge clk);
      start = 1'b0;
      check(error == 1'b1, "R7 error pulse", error, 1);
      check(!bus_we && !busy, "R7 no bus cycle", {bus_we, busy}, 0);
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         check(!error && !bus_we && !busy && !din_ready, "R7 stays idle",
               {error, bus_we, busy, din_ready}, 0);
      end
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      // R9 reset state
      check({bus_we, done, error, busy, din_ready} == 5'b0, "R9 reset", {bus_we, done, error, busy, din_ready}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check({bus_we, done, error, busy, din_ready} == 5'b0, "R9 after release", {bus_we, done, error, busy, din_ready}, 0);

      run_bad(0);                                  // R7 zero count
      run_bad(MAX_WORDS + 1);                      // R7 oversize
      run_bad(200);                                // R7 far oversize
      run_xfer(AW'(24'h001000), 1, 1'b0);          // R10 single word
      run_xfer(AW'(24'h002000), MAX_WORDS, 1'b0);  // R10 full buffer
      run_xfer(AW'(24'hFFFFFE), 4, 1'b0);          // R4 address wrap
      run_xfer(AW'(24'h003100), 12, 1'b1);         // R8 start while busy
      for (int t = 0; t < 8; t++) begin
         run_xfer(AW'($urandom), 1 + ($urandom % MAX_WORDS), 1'b0);
      end
      run_bad(0);                                  // R7 after traffic

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule